// File: doc/BRIEF.md
# Fracturable Lookup-Table Logic Cell

This block is one programmable logic cell of the kind tiled across a reconfigurable fabric. It has eight data inputs: four shared ones (a, b, c, d) and one private pair (e, f) for each of its two halves. Each half holds a 64-entry truth table. The cell runs in one of four modes. In the first, each half computes its own function. In the second and third, a single half computes any 6-input function and the other half's combinational output is held low. In the fourth, both halves apply the same table to their own select inputs, for example two 4-to-1 muxes over common data.

Each half also owns a register with asynchronous clear, asynchronous load, synchronous clear, synchronous load and clock enable. The register can capture the half's LUT result. It can also capture the half's f input directly (packing), so that it serves logic unrelated to the LUT. A third choice is the chain path: half 0 takes an external chain input, half 1 takes half 0's register, and half 1's register drives the chain output. A per-half feedback option feeds the half's own register output into its LUT in place of the f input. A status bit flags a split-mode configuration whose two functions could not share the cell's input wiring.

The configuration is loaded in one clock through a parallel write port. Other logic drives the data and control inputs, and the combinational and registered outputs of both halves are all visible at once.

Top module: `flut_cell`

## Requirements
- R1: On a clock edge with `cfg_we_i` high, the whole configuration word is stored. With `cfg_we_i` low, a change on `cfg_word_i` has no effect. The word layout is: bits [63:0] table 0; [127:64] table 1; [129:128] mode; [131:130] source of half 0; [132] feedback of half 0; [134:133] source of half 1; [135] feedback of half 1.
- R2: In mode 0 (split), `comb_o[0]` equals bit {f0,e0,d,c,b,a} of table 0, and `comb_o[1]` equals bit {f1,e1,d,c,b,a} of table 1. In each index, f is the most significant bit and a the least.
- R3: In mode 1 (wide on half 0), `comb_o[0]` follows table 0 and `comb_o[1]` is 0. In mode 2 (wide on half 1), `comb_o[1]` follows table 1 and `comb_o[0]` is 0.
- R4: In mode 3 (twin), both halves read table 0 with their own indices, and table 1 is ignored.
- R5: `illegal_o` is 1 only in split mode, and only when both tables depend on at least one input and one of these holds: a table depends on 6 inputs and the two tables differ; both tables depend on 5 inputs and do not both use a and b; the tables depend on 5 and 4 inputs and share neither a nor b. All other cases, and every other mode, give 0.
- R6: With source 0 (LUT), a half's register takes that half's `comb_o` on a clock edge where `ena_i` is high. With `ena_i` low and no other control active, it holds.
- R7: Synchronous clear wins over synchronous load, which wins over enabled capture. Synchronous load stores the half's e input.
- R8: `aclr_i` clears both registers at once, without a clock, and wins over `aload_i`. `aload_i` loads each register with its half's e input when it is asserted, and on every clock edge while it stays high.
- R9: With source 2 (packing), the register captures the half's f input, while `comb_o` keeps showing the LUT function.
- R10: With source 1 (chain), half 0 captures `chain_i` and half 1 captures half 0's register. `chain_o` shows half 1's register.
- R11: With the feedback bit set, the half's LUT sees its own register output in place of its f input.
- R12: `rst_ni` low clears the configuration and both registers asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_word_i | input | 136 | Configuration word |
| in_a_i | input | 1 | Shared data input a |
| in_b_i | input | 1 | Shared data input b |
| in_c_i | input | 1 | Shared data input c |
| in_d_i | input | 1 | Shared data input d |
| in_e_i | input | 2 | Private e input per half |
| in_f_i | input | 2 | Private f input per half |
| ena_i | input | 1 | Register clock enable |
| sclr_i | input | 1 | Synchronous clear |
| sload_i | input | 1 | Synchronous load from e |
| aclr_i | input | 1 | Asynchronous clear |
| aload_i | input | 1 | Asynchronous load from e |
| chain_i | input | 1 | Register chain input from the neighbouring cell |
| comb_o | output | 2 | Combinational output per half |
| reg_o | output | 2 | Registered output per half |
| chain_o | output | 1 | Register chain output |
| illegal_o | output | 1 | Input-sharing rule violated |

## Verification
The register controls can fall in the same cycle. Enable, synchronous clear and synchronous load are raised together, and the captured value is compared with the one priority-winning source. The bench picks data for which the LUT result and the e input disagree in both halves. Asynchronous clear and asynchronous load are also held together between clock edges, and the register must read zero before and after the next edge. Packing is judged by comparing the combinational output and the registered output of the same half in the same cycle, since the two must carry unrelated values.

// File: rtl/flut_pkg.sv
package flut_pkg;
  localparam int LUT_K   = 6;
  localparam int TT_W    = 1 << LUT_K;
  localparam int HCFG_W  = 3;
  localparam int MODE_LO = 2 * TT_W;
  localparam int HCFG_LO = MODE_LO + 2;
  localparam int CFG_W   = HCFG_LO + 2 * HCFG_W;

  typedef enum logic [1:0] {
    MODE_SPLIT = 2'd0,
    MODE_WIDE0 = 2'd1,
    MODE_WIDE1 = 2'd2,
    MODE_TWIN  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    SRC_LUT   = 2'd0,
    SRC_CHAIN = 2'd1,
    SRC_PACK  = 2'd2,
    SRC_RSVD  = 2'd3
  } src_e;

  typedef struct packed {
    logic fb;
    src_e src;
  } hcfg_t;
endpackage

// File: rtl/flut_dep.sv
module flut_dep #(
  parameter int K = 6,
  localparam int W = 1 << K
) (
  input  logic [W-1:0] tt_i,
  output logic [K-1:0] dep_o
);
  // input k matters if any pair of entries differing only in bit k disagree
  always_comb begin
    dep_o = '0;
    for (int k = 0; k < K; k++) begin
      for (int i = 0; i < W; i++) begin
        if (((i >> k) & 1) == 0) begin
          dep_o[k] = dep_o[k] | (tt_i[i] ^ tt_i[i + (1 << k)]);
        end
      end
    end
  end
endmodule

// File: rtl/flut_legal.sv
module flut_legal
  import flut_pkg::*;
#(
  parameter int K = 6,
  localparam int W = 1 << K
) (
  input  mode_e        mode_i,
  input  logic [W-1:0] tt0_i,
  input  logic [W-1:0] tt1_i,
  input  logic [K-1:0] dep0_i,
  input  logic [K-1:0] dep1_i,
  output logic         illegal_o
);
  int   n0, n1, hi, lo;
  logic share_a, share_b, ok;

  always_comb begin
    n0 = $countones(dep0_i);
    n1 = $countones(dep1_i);
    hi = (n0 > n1) ? n0 : n1;
    lo = (n0 > n1) ? n1 : n0;
    share_a = dep0_i[0] & dep1_i[0];
    share_b = dep0_i[1] & dep1_i[1];
    ok = 1'b1;
    if (mode_i == MODE_SPLIT && lo != 0) begin
      if (hi == K)                     ok = (tt0_i == tt1_i);
      else if (hi == K-1 && lo == K-1) ok = share_a & share_b;
      else if (hi == K-1 && lo == K-2) ok = share_a | share_b;
    end
    illegal_o = ~ok;
  end
endmodule

// File: rtl/flut_reg.sv
module flut_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic aclr_i,
  input  logic aload_i,
  input  logic ld_d_i,
  input  logic sclr_i,
  input  logic sload_i,
  input  logic ena_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni or posedge aclr_i or posedge aload_i) begin
    if (!rst_ni)      q_o <= 1'b0;
    else if (aclr_i)  q_o <= 1'b0;
    else if (aload_i) q_o <= ld_d_i;
    else if (sclr_i)  q_o <= 1'b0;
    else if (sload_i) q_o <= ld_d_i;
    else if (ena_i)   q_o <= d_i;
  end
endmodule

// File: rtl/flut_cell.sv
module flut_cell
  import flut_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_word_i,
  input  logic             in_a_i,
  input  logic             in_b_i,
  input  logic             in_c_i,
  input  logic             in_d_i,
  input  logic [1:0]       in_e_i,
  input  logic [1:0]       in_f_i,
  input  logic             ena_i,
  input  logic             sclr_i,
  input  logic             sload_i,
  input  logic             aclr_i,
  input  logic             aload_i,
  input  logic             chain_i,
  output logic [1:0]       comb_o,
  output logic [1:0]       reg_o,
  output logic             chain_o,
  output logic             illegal_o
);
  logic [CFG_W-1:0]           cfg_q;
  logic [1:0][TT_W-1:0]       tt_cfg;
  logic [1:0][TT_W-1:0]       tt_sel;
  logic [1:0][LUT_K-1:0]      dep;
  logic [1:0][LUT_K-1:0]      lut_in;
  logic [1:0]                 reg_d;
  logic [1:0]                 reg_q;
  hcfg_t                      hcfg [2];
  mode_e                      cfg_mode;
  src_e                       cfg_src1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_word_i;
  end

  assign cfg_mode = mode_e'(cfg_q[MODE_LO +: 2]);
  assign cfg_src1 = hcfg[1].src;

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign tt_cfg[h] = cfg_q[h*TT_W +: TT_W];
    assign hcfg[h]   = hcfg_t'(cfg_q[HCFG_LO + h*HCFG_W +: HCFG_W]);

    flut_dep #(.K(LUT_K)) u_dep (
      .tt_i  (tt_cfg[h]),
      .dep_o (dep[h])
    );

    // twin mode: half 1 reuses table 0
    if (h == 0) begin : g_t0
      assign tt_sel[h] = tt_cfg[0];
    end else begin : g_t1
      assign tt_sel[h] = (cfg_mode == MODE_TWIN) ? tt_cfg[0] : tt_cfg[1];
    end

    assign lut_in[h] = {(hcfg[h].fb ? reg_q[h] : in_f_i[h]), in_e_i[h],
                        in_d_i, in_c_i, in_b_i, in_a_i};

    logic half_on;
    assign half_on   = (h == 0) ? (cfg_mode != MODE_WIDE1) : (cfg_mode != MODE_WIDE0);
    assign comb_o[h] = half_on & tt_sel[h][lut_in[h]];

    always_comb begin
      unique case (hcfg[h].src)
        SRC_CHAIN: reg_d[h] = (h == 0) ? chain_i : reg_q[0];
        SRC_PACK:  reg_d[h] = in_f_i[h];
        default:   reg_d[h] = comb_o[h];
      endcase
    end

    flut_reg u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .aclr_i  (aclr_i),
      .aload_i (aload_i),
      .ld_d_i  (in_e_i[h]),
      .sclr_i  (sclr_i),
      .sload_i (sload_i),
      .ena_i   (ena_i),
      .d_i     (reg_d[h]),
      .q_o     (reg_q[h])
    );
  end

  flut_legal #(.K(LUT_K)) u_legal (
    .mode_i    (cfg_mode),
    .tt0_i     (tt_cfg[0]),
    .tt1_i     (tt_cfg[1]),
    .dep0_i    (dep[0]),
    .dep1_i    (dep[1]),
    .illegal_o (illegal_o)
  );

  assign reg_o   = reg_q;
  assign chain_o = reg_q[1];
endmodule

// File: rtl/flut_cell_chk.sv
module flut_cell_chk
  import flut_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [CFG_W-1:0] cfg_word_i,
  input logic             ena_i,
  input logic             sclr_i,
  input logic             sload_i,
  input logic             aclr_i,
  input logic             aload_i,
  input logic [1:0]       comb_o,
  input logic [1:0]       reg_o,
  input logic             illegal_o,
  input logic [CFG_W-1:0] cfg_q_i,
  input mode_e            mode_i,
  input src_e             src1_i
);
  AST_CFG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_q_i == $past(cfg_word_i)); // R1

  AST_WIDE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_WIDE0 |-> !comb_o[1]) and (mode_i == MODE_WIDE1 |-> !comb_o[0])); // R3

  AST_NONSPLIT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i != MODE_SPLIT |-> !illegal_o); // R5

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ena_i && !sclr_i && !sload_i && !aclr_i && !aload_i)
    |=> (aclr_i || aload_i || $stable(reg_o))); // R6

  AST_SCLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclr_i && !aclr_i && !aload_i) |=> (aload_i || reg_o == 2'b00)); // R7

  AST_ACLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aclr_i |-> reg_o == 2'b00); // R8

  AST_CHAIN_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src1_i == SRC_CHAIN && ena_i && !sclr_i && !sload_i && !aclr_i && !aload_i)
    |=> (aclr_i || aload_i || reg_o[1] == $past(reg_o[0]))); // R10
endmodule

bind flut_cell flut_cell_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_word_i (cfg_word_i),
  .ena_i      (ena_i),
  .sclr_i     (sclr_i),
  .sload_i    (sload_i),
  .aclr_i     (aclr_i),
  .aload_i    (aload_i),
  .comb_o     (comb_o),
  .reg_o      (reg_o),
  .illegal_o  (illegal_o),
  .cfg_q_i    (cfg_q),
  .mode_i     (cfg_mode),
  .src1_i     (cfg_src1)
);

// File: tb/flut_cell_bench.sv
module flut_cell_bench;
  import flut_pkg::*;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_we_i = 1'b0;
  logic [CFG_W-1:0] cfg_word_i = '0;
  logic             in_a_i = 0, in_b_i = 0, in_c_i = 0, in_d_i = 0;
  logic [1:0]       in_e_i = '0, in_f_i = '0;
  logic             ena_i = 0, sclr_i = 0, sload_i = 0, aclr_i = 0, aload_i = 0, chain_i = 0;
  logic [1:0]       comb_o, reg_o;
  logic             chain_o, illegal_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  flut_cell u_flut_cell (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [TT_W-1:0] xor_tt(logic [5:0] m);
    logic [TT_W-1:0] t;
    for (int i = 0; i < TT_W; i++) t[i] = ^(6'(i) & m);
    return t;
  endfunction

  function automatic logic [TT_W-1:0] and_tt(logic [5:0] m);
    logic [TT_W-1:0] t;
    for (int i = 0; i < TT_W; i++) t[i] = ((6'(i) & m) == m);
    return t;
  endfunction

  function automatic logic [CFG_W-1:0] mk_cfg(logic [TT_W-1:0] t0, logic [TT_W-1:0] t1,
      logic [1:0] mode, logic [1:0] s0, logic f0, logic [1:0] s1, logic f1);
    return {f1, s1, f0, s0, mode, t1, t0};
  endfunction

  // v = {f1,e1,f0,e0,d,c,b,a}
  task automatic set_in(logic [7:0] v);
    {in_f_i[1], in_e_i[1], in_f_i[0], in_e_i[0], in_d_i, in_c_i, in_b_i, in_a_i} = v;
  endtask

  task automatic load_cfg(logic [CFG_W-1:0] w);
    @(negedge clk_i);
    cfg_word_i = w;
    cfg_we_i   = 1'b1;
    @(negedge clk_i);
    cfg_we_i   = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk_legal(logic [TT_W-1:0] t0, logic [TT_W-1:0] t1, logic exp, string tag);
    load_cfg(mk_cfg(t0, t1, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0));
    #1;
    check({"R5 ", tag}, 32'(illegal_o), 32'(exp));
  endtask

  initial begin
    #(200000 * 10);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [5:0] i0, i1;
    #12;
    check("R12 reset reg", 32'(reg_o), 0);
    check("R12 reset comb", 32'(comb_o), 0);
    check("R1 reset legal", 32'(illegal_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 split sweep, two table pairs
    load_cfg(mk_cfg(xor_tt(6'h3F), and_tt(6'h15), 2'd0, 2'd0, 1'b0, 2'd0, 1'b0));
    for (int v = 0; v < 256; v++) begin
      set_in(8'(v)); #1;
      i0 = 6'(v); i1 = {8'(v) >> 6, 4'(v)};
      check("R2 split h0", 32'(comb_o[0]), 32'(^i0));
      check("R2 split h1", 32'(comb_o[1]), 32'((i1 & 6'h15) == 6'h15));
    end
    load_cfg(mk_cfg(and_tt(6'h0F), xor_tt(6'h33), 2'd0, 2'd0, 1'b0, 2'd0, 1'b0));
    for (int v = 0; v < 256; v++) begin
      set_in(8'(v)); #1;
      i0 = 6'(v); i1 = {8'(v) >> 6, 4'(v)};
      check("R2 split2 h0", 32'(comb_o[0]), 32'((i0 & 6'h0F) == 6'h0F));
      check("R2 split2 h1", 32'(comb_o[1]), 32'(^(i1 & 6'h33)));
    end

    // R1 write strobe low: word change ignored
    @(negedge clk_i);
    set_in(8'h0F);
    cfg_word_i = '0;
    tick();
    check("R1 no write", 32'(comb_o), 32'(2'b01));

    // R3 wide modes
    load_cfg(mk_cfg(xor_tt(6'h3F), xor_tt(6'h3F), 2'd1, 2'd0, 1'b0, 2'd0, 1'b0));
    for (int v = 0; v < 256; v += 3) begin
      set_in(8'(v)); #1;
      check("R3 wide0 h0", 32'(comb_o[0]), 32'(^(6'(v))));
      check("R3 wide0 h1", 32'(comb_o[1]), 0);
    end
    load_cfg(mk_cfg(xor_tt(6'h3F), xor_tt(6'h3F), 2'd2, 2'd0, 1'b0, 2'd0, 1'b0));
    for (int v = 0; v < 256; v += 3) begin
      set_in(8'(v)); #1;
      i1 = {8'(v) >> 6, 4'(v)};
      check("R3 wide1 h0", 32'(comb_o[0]), 0);
      check("R3 wide1 h1", 32'(comb_o[1]), 32'(^i1));
    end

    // R4 twin mode, table 1 set to complement
    load_cfg(mk_cfg(xor_tt(6'h31), ~xor_tt(6'h31), 2'd3, 2'd0, 1'b0, 2'd0, 1'b0));
    for (int v = 0; v < 256; v++) begin
      set_in(8'(v)); #1;
      i0 = 6'(v); i1 = {8'(v) >> 6, 4'(v)};
      check("R4 twin h0", 32'(comb_o[0]), 32'(^(i0 & 6'h31)));
      check("R4 twin h1", 32'(comb_o[1]), 32'(^(i1 & 6'h31)));
    end

    // R5 legality
    chk_legal(xor_tt(6'h0F), xor_tt(6'h0F), 1'b0, "4+4");
    chk_legal(xor_tt(6'h1F), xor_tt(6'h07), 1'b0, "5+3");
    chk_legal(xor_tt(6'h1F), xor_tt(6'h1F), 1'b0, "5+5 share ab");
    chk_legal(xor_tt(6'h1F), xor_tt(6'h3E), 1'b1, "5+5 no a");
    chk_legal(xor_tt(6'h1F), xor_tt(6'h3A), 1'b0, "5+4 share b");
    chk_legal(xor_tt(6'h1F), xor_tt(6'h3C), 1'b1, "5+4 no ab");
    chk_legal(xor_tt(6'h3C), xor_tt(6'h1F), 1'b1, "4+5 no ab");
    chk_legal(xor_tt(6'h3F), xor_tt(6'h3F), 1'b0, "6+6 same");
    chk_legal(xor_tt(6'h3F), and_tt(6'h3F), 1'b1, "6+6 differ");
    chk_legal(xor_tt(6'h3F), '0, 1'b0, "6+0");
    chk_legal(xor_tt(6'h3F), xor_tt(6'h01), 1'b1, "6+1");
    chk_legal('0, '0, 1'b0, "0+0");
    for (int m = 1; m < 4; m++) begin
      load_cfg(mk_cfg(xor_tt(6'h3F), and_tt(6'h3F), 2'(m), 2'd0, 1'b0, 2'd0, 1'b0));
      #1;
      check("R5 non-split legal", 32'(illegal_o), 0);
    end

    // R6 capture and hold
    load_cfg(mk_cfg(xor_tt(6'h3F), xor_tt(6'h0F), 2'd0, 2'd0, 1'b0, 2'd0, 1'b0));
    @(negedge clk_i); set_in(8'h07); ena_i = 1;
    tick();
    check("R6 capture", 32'(reg_o), 32'(2'b11));
    @(negedge clk_i); ena_i = 0; set_in(8'h03);
    tick();
    check("R6 hold", 32'(reg_o), 32'(2'b11));
    // R7 priority among synchronous controls
    @(negedge clk_i); ena_i = 1; sclr_i = 1; sload_i = 1; set_in(8'h11);
    tick();
    check("R7 sclr wins", 32'(reg_o), 0);
    @(negedge clk_i); sclr_i = 0;
    tick();
    check("R7 sload wins", 32'(reg_o), 32'(2'b01));
    // R8 asynchronous controls
    @(negedge clk_i); sload_i = 0; ena_i = 0; aclr_i = 1; #1;
    check("R8 aclr async", 32'(reg_o), 0);
    aload_i = 1; set_in(8'h50); #1;
    check("R8 aclr over aload", 32'(reg_o), 0);
    tick();
    check("R8 aclr held", 32'(reg_o), 0);
    @(negedge clk_i); aclr_i = 0; aload_i = 0;
    @(negedge clk_i); aload_i = 1; #1;
    check("R8 aload async", 32'(reg_o), 32'(2'b11));
    @(negedge clk_i); set_in(8'h10);
    tick();
    check("R8 aload on edge", 32'(reg_o), 32'(2'b01));
    @(negedge clk_i); aload_i = 0;

    // R9 packing
    load_cfg(mk_cfg(xor_tt(6'h3F), xor_tt(6'h0F), 2'd0, 2'd2, 1'b0, 2'd2, 1'b0));
    @(negedge clk_i); set_in(8'h21); ena_i = 1;
    tick();
    check("R9 pack reg", 32'(reg_o), 32'(2'b01));
    check("R9 pack comb", 32'(comb_o), 32'(2'b10));

    // R10 chain
    @(negedge clk_i); ena_i = 0;
    load_cfg(mk_cfg(xor_tt(6'h3F), xor_tt(6'h0F), 2'd0, 2'd1, 1'b0, 2'd1, 1'b0));
    @(negedge clk_i); chain_i = 0; ena_i = 1;
    tick();
    check("R10 chain shift1", 32'(reg_o), 32'(2'b10));
    check("R10 chain out1", 32'(chain_o), 1);
    @(negedge clk_i); chain_i = 1;
    tick();
    check("R10 chain shift2", 32'(reg_o), 32'(2'b01));
    check("R10 chain out2", 32'(chain_o), 0);
    tick();
    check("R10 chain shift3", 32'(reg_o), 32'(2'b11));

    // R11 feedback: table = not f, so the register toggles
    @(negedge clk_i); ena_i = 0;
    load_cfg(mk_cfg(~xor_tt(6'h20), '0, 2'd0, 2'd0, 1'b1, 2'd0, 1'b0));
    set_in(8'h00); #1;
    check("R11 fb comb", 32'(comb_o[0]), 0);
    @(negedge clk_i); ena_i = 1;
    tick();
    check("R11 fb toggle1", 32'(reg_o[0]), 0);
    check("R11 fb comb1", 32'(comb_o[0]), 1);
    tick();
    check("R11 fb toggle2", 32'(reg_o[0]), 1);

    // R12 asynchronous reset mid run
    @(negedge clk_i); ena_i = 0; set_in(8'hFF); rst_ni = 0; #1;
    check("R12 rst reg", 32'(reg_o), 0);
    check("R12 rst cfg", 32'(comb_o), 0);
    @(negedge clk_i); rst_ni = 1;
    tick();
    check("R12 rst cfg after", 32'(comb_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule